// File: doc/BRIEF.md
# Burst Column Address Generator

This block turns one column access command into a stream of column addresses, one per clock, for a memory that is read or written in bursts. A command supplies a start column, a burst length code and an ordering bit. For the following beats the block presents the column to access, a valid flag, and a flag that marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned window that holds the start column. Sequential ordering counts upward in the low window bits and never carries into the bits above them. Interleaved ordering forms each address as the start column XOR the beat index. Full-page bursts walk through every column of the page, wrapping from the top column to zero, until a stop arrives. A new command may cut into a running burst. It discards the beats that remain and starts a complete new burst at its own column.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released with no command, `valid_o` and `last_o` are low.
- R2: `bl_code_i` values 0, 1, 2 and 3 select 1, 2, 4 and 8 beats. Value 7 selects full page. Values 4, 5 and 6 behave as length 1, so the first beat is also the last.
- R3: In sequential order (`ilv_i` = 0) with length L, beat k is at ((start mod L) + k) mod L inside the L-aligned window of the start column. The bits above that window keep their start values.
- R4: In interleaved order (`ilv_i` = 1) with a fixed length, beat k is at start XOR k.
- R5: In full-page mode, beat k is at (start + k) mod 512. `ilv_i` has no effect, and the burst does not end by itself.
- R6: `last_o` is high only on the final beat of a fixed-length burst, and never in full-page mode. After a final beat with no new command, `valid_o` goes low.
- R7: A `start_i` pulse during a burst drops the remaining beats. The next cycle shows beat 0 of a complete burst at the new column, using the new length and order.
- R8: A `restart_i` pulse (without `start_i`) begins a complete burst at `col_i` and keeps the length and order latched by the last `start_i`.
- R9: `stop_i` with no `start_i` or `restart_i` in the same cycle ends any burst, and `valid_o` is low the next cycle. `start_i` takes priority over `restart_i`, and `restart_i` takes priority over `stop_i`.
- R10: Beat 0 appears in the cycle after the command edge, and each following beat appears one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | New command: latch column, length and order |
| col_i | input | 9 | Start column |
| bl_code_i | input | 3 | Burst length code |
| ilv_i | input | 1 | Ordering: 0 sequential, 1 interleaved |
| stop_i | input | 1 | End the current burst |
| restart_i | input | 1 | New burst at `col_i` using the latched length and order |
| col_o | output | 9 | Column address of the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Directed bursts are aimed at the boundaries. A sequential burst that starts near the top of the page shows that the window wraps without carrying. An interleaved burst from an odd column tells XOR ordering apart from incrementing. A full-page burst across column 511 shows the wrap to zero and that the ordering bit is ignored. Cut-in cases separate `start_i` from `restart_i` by whether the length and order are reloaded, and a reserved length code shows it collapses to one beat. Random streams that mix commands, stops and every length code are then compared beat by beat against a model in the bench.

// File: rtl/bcg_pkg.sv
`timescale 1ns/1ps
package bcg_pkg;
  localparam int BLC_W  = 3;  // burst length code width
  localparam int LG_W   = 2;  // log2 of fixed burst length
  localparam int LG_MAX = 3;  // largest fixed burst is 2**LG_MAX beats

  typedef enum logic [1:0] {
    ORD_SEQ  = 2'd0,
    ORD_ILV  = 2'd1,
    ORD_FULL = 2'd2
  } order_e;

  typedef struct packed {
    order_e            ord;
    logic [LG_W-1:0]   lg;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_RESET = '{ord: ORD_SEQ, lg: '0};
endpackage

// File: rtl/bcg_len_decode.sv
`timescale 1ns/1ps
module bcg_len_decode
  import bcg_pkg::*;
(
  input  logic [BLC_W-1:0] code_i,
  input  logic             ilv_i,
  output burst_cfg_t       cfg_o
);
  localparam logic [BLC_W-1:0] CODE_FULL = BLC_W'(7);

  function automatic burst_cfg_t decode(input logic [BLC_W-1:0] code, input logic ilv);
    burst_cfg_t c;
    c.ord = ilv ? ORD_ILV : ORD_SEQ;
    c.lg  = '0;
    if (code == CODE_FULL) begin
      c.ord = ORD_FULL;
    end else if (code <= BLC_W'(LG_MAX)) begin
      c.lg = LG_W'(code);
    end
    return c;
  endfunction

  always_comb cfg_o = decode(code_i, ilv_i);
endmodule

// File: rtl/bcg_beat_counter.sv
`timescale 1ns/1ps
module bcg_beat_counter
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic             full_i,
  input  logic [LG_W-1:0]  lg_i,
  output logic             active_o,
  output logic [COL_W-1:0] cnt_o,
  output logic             last_o
);
  function automatic logic [COL_W-1:0] final_index(input logic [LG_W-1:0] lg);
    return COL_W'((1 << lg) - 1);
  endfunction

  logic             active_q;
  logic [COL_W-1:0] cnt_q;
  logic             beat_adv;
  logic             burst_done;

  assign burst_done = active_q && !full_i && (cnt_q == final_index(lg_i));
  assign beat_adv   = active_q && !burst_done && !stop_i && !load_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (load_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (stop_i || burst_done) begin
      active_q <= 1'b0;
    end else if (beat_adv) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
  assign last_o   = burst_done;

  assert_last_in_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> (active_o && !full_i));
  assert_end_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !load_i) |=> !active_o);
  assert_stop_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !load_i) |=> !active_o);
  assert_load_begins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (active_o && cnt_o == '0));
endmodule

// File: rtl/bcg_addr_order.sv
`timescale 1ns/1ps
module bcg_addr_order
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  burst_cfg_t       cfg_i,
  output logic [COL_W-1:0] win_mask_o,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] win_mask;

  // window mask: bit i is inside the burst window when i < lg
  genvar gi;
  generate
    for (gi = 0; gi < COL_W; gi++) begin : g_mask
      if (gi < LG_MAX) begin : g_low
        assign win_mask[gi] = (cfg_i.ord != ORD_FULL) && (LG_W'(gi) < cfg_i.lg);
      end else begin : g_high
        assign win_mask[gi] = 1'b0;
      end
    end
  endgenerate

  function automatic logic [COL_W-1:0] seq_addr(input logic [COL_W-1:0] base,
                                                input logic [COL_W-1:0] cnt,
                                                input logic [COL_W-1:0] mask);
    return (base & ~mask) | ((base + cnt) & mask);
  endfunction

  function automatic logic [COL_W-1:0] ilv_addr(input logic [COL_W-1:0] base,
                                                input logic [COL_W-1:0] cnt);
    return base ^ cnt;
  endfunction

  function automatic logic [COL_W-1:0] page_addr(input logic [COL_W-1:0] base,
                                                 input logic [COL_W-1:0] cnt);
    return base + cnt;
  endfunction

  always_comb begin
    unique case (cfg_i.ord)
      ORD_ILV:  col_o = ilv_addr(base_i, cnt_i);
      ORD_FULL: col_o = page_addr(base_i, cnt_i);
      default:  col_o = seq_addr(base_i, cnt_i, win_mask);
    endcase
  end

  assign win_mask_o = win_mask;
endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
module burst_col_gen
  import bcg_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [BLC_W-1:0] bl_code_i,
  input  logic             ilv_i,
  input  logic             stop_i,
  input  logic             restart_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  burst_cfg_t       cfg_dec;
  burst_cfg_t       cfg_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] cnt;
  logic [COL_W-1:0] win_mask;
  logic             load;
  logic             active;
  logic             fp_mode;
  logic             quiet;

  assign load    = start_i | restart_i;
  assign fp_mode = (cfg_q.ord == ORD_FULL);
  assign quiet   = !start_i && !restart_i && !stop_i;

  bcg_len_decode u_dec (
    .code_i (bl_code_i),
    .ilv_i  (ilv_i),
    .cfg_o  (cfg_dec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      base_q <= '0;
    end else begin
      if (start_i) cfg_q  <= cfg_dec;
      if (load)    base_q <= col_i;
    end
  end

  bcg_beat_counter #(.COL_W(COL_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .stop_i   (stop_i),
    .full_i   (fp_mode),
    .lg_i     (cfg_q.lg),
    .active_o (active),
    .cnt_o    (cnt),
    .last_o   (last_o)
  );

  bcg_addr_order #(.COL_W(COL_W)) u_ord (
    .base_i     (base_q),
    .cnt_i      (cnt),
    .cfg_i      (cfg_q),
    .win_mask_o (win_mask),
    .col_o      (col_o)
  );

  assign valid_o = active;

  assert_cut_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(col_i)));
  assert_restart_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_i && !start_i) |=> (valid_o && col_o == $past(col_i)));
  assert_reserved_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && bl_code_i inside {3'd4, 3'd5, 3'd6}) |=> last_o);
  assert_full_no_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && bl_code_i == 3'd7) |=> !last_o);
  assert_no_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !last_o && !fp_mode && quiet) |=>
      (valid_o && (col_o & ~win_mask) == ($past(col_o) & ~win_mask)));
  assert_page_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && fp_mode && quiet) |=>
      (valid_o && col_o == COL_W'($past(col_o) + 1'b1)));
  assert_idle_no_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> !last_o);
endmodule

// File: tb/burst_col_gen_tb_top.sv
`timescale 1ns/1ps
module burst_col_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [8:0] col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       ilv_i = 1'b0;
  logic       stop_i = 1'b0;
  logic       restart_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o;
  logic       last_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference model state
  bit m_act = 0;
  int m_cnt = 0;
  int m_base = 0;
  int m_len = 1;   // 0 means full page
  bit m_ilv = 0;

  always #2.5 clk = ~clk;

  burst_col_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_i(col_i),
    .bl_code_i(bl_code_i), .ilv_i(ilv_i), .stop_i(stop_i),
    .restart_i(restart_i), .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  function automatic int len_of(int code);
    if (code == 7) return 0;
    if (code < 4) return 1 << code;
    return 1;
  endfunction

  function automatic int exp_col();
    int lo;
    if (m_len == 0) return (m_base + m_cnt) % 512;
    if (m_ilv) return m_base ^ m_cnt;
    lo = m_base % m_len;
    return m_base - lo + ((lo + m_cnt) % m_len);
  endfunction

  function automatic bit exp_last();
    return m_act && m_len != 0 && m_cnt == m_len - 1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare outputs with the model, then drive the next inputs and advance the model
  task automatic step(bit st, bit rs, bit sp, int col, int code, bit ilv);
    @(negedge clk);
    chk(cur_tag, valid_o, m_act);
    chk("R6", last_o, exp_last());
    if (m_act) chk(m_len == 0 ? "R5" : (m_ilv ? "R4" : "R3"), col_o, exp_col());
    start_i = st; restart_i = rs; stop_i = sp;
    col_i = col[8:0]; bl_code_i = code[2:0]; ilv_i = ilv;
    if (st) begin
      m_act = 1; m_cnt = 0; m_base = col; m_len = len_of(code); m_ilv = ilv;
    end else if (rs) begin
      m_act = 1; m_cnt = 0; m_base = col;
    end else if (sp) begin
      m_act = 0;
    end else if (m_act) begin
      if (exp_last()) m_act = 0;
      else m_cnt = (m_cnt + 1) % 512;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    chk("R1", valid_o, 0);
    chk("R1", last_o, 0);
    rst_n = 1'b1;
    cur_tag = "R1";
    idle(2);

    // sequential, 4 beats near top of page: no carry out of the window
    cur_tag = "R10";
    step(1, 0, 0, 510, 2, 0);
    step(0, 0, 0, 0, 0, 0); chk("R10", col_o, 510);
    step(0, 0, 0, 0, 0, 0); chk("R3", col_o, 511);
    step(0, 0, 0, 0, 0, 0); chk("R3", col_o, 508);
    step(0, 0, 0, 0, 0, 0); chk("R3", col_o, 509); chk("R6", last_o, 1);
    step(0, 0, 0, 0, 0, 0); chk("R6", valid_o, 0);

    // interleaved, 8 beats from column 11
    cur_tag = "R4";
    step(1, 0, 0, 11, 3, 1);
    step(0, 0, 0, 0, 0, 0); chk("R4", col_o, 11);
    step(0, 0, 0, 0, 0, 0); chk("R4", col_o, 10);
    step(0, 0, 0, 0, 0, 0); chk("R4", col_o, 9);
    step(0, 0, 0, 0, 0, 0); chk("R4", col_o, 8);
    step(0, 0, 0, 0, 0, 0); chk("R4", col_o, 15);
    idle(4);

    // full page across the top, interleave bit set but ignored, then stop
    cur_tag = "R5";
    step(1, 0, 0, 510, 7, 1);
    step(0, 0, 0, 0, 0, 0); chk("R5", col_o, 510);
    step(0, 0, 0, 0, 0, 0); chk("R5", col_o, 511);
    step(0, 0, 0, 0, 0, 0); chk("R5", col_o, 0); chk("R6", last_o, 0);
    idle(20);
    chk("R5", valid_o, 1);
    cur_tag = "R9";
    step(0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0); chk("R9", valid_o, 0);

    // reserved length code collapses to one beat
    cur_tag = "R2";
    step(1, 0, 0, 100, 5, 0);
    step(0, 0, 0, 0, 0, 0); chk("R2", last_o, 1); chk("R2", col_o, 100);
    step(0, 0, 0, 0, 0, 0); chk("R2", valid_o, 0);

    // start cuts in with new length and column
    cur_tag = "R7";
    step(1, 0, 0, 0, 3, 0);
    idle(2);
    step(1, 0, 0, 33, 1, 0);
    step(0, 0, 0, 0, 0, 0); chk("R7", col_o, 33);
    step(0, 0, 0, 0, 0, 0); chk("R7", col_o, 32); chk("R7", last_o, 1);
    step(0, 0, 0, 0, 0, 0); chk("R7", valid_o, 0);

    // restart keeps interleaved length 4; the code on the pins is ignored
    cur_tag = "R8";
    step(1, 0, 0, 5, 2, 1);
    step(0, 0, 0, 0, 0, 0);
    step(0, 1, 1, 9, 7, 0);
    step(0, 0, 0, 0, 0, 0); chk("R8", col_o, 9);
    step(0, 0, 0, 0, 0, 0); chk("R8", col_o, 8);
    step(0, 0, 0, 0, 0, 0); chk("R8", col_o, 11);
    step(0, 0, 0, 0, 0, 0); chk("R8", col_o, 10); chk("R8", last_o, 1);
    idle(2);

    // random mix checked against the model
    cur_tag = "R9";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      bit st = (r < 10);
      bit rs = (r >= 10 && r < 15) || (r == 99);
      bit sp = (r >= 15 && r < 19) || (r >= 97);
      step(st, rs, sp, $urandom_range(0, 511), $urandom_range(0, 7), 1'($urandom_range(0, 1)));
    end
    idle(3);
    finish_run();
  end
endmodule